// File: doc/BRIEF.md
# Trigger-Positioned Capture Buffer Controller

This block sequences writes into an on-chip sample memory that records a probe bus once per rising clock edge while an acquisition is running. A host pulses `arm_i` with a mode, a trigger position and a segment count. The controller then writes continuously, wrapping inside the active region of memory, until a qualified trigger arrives. After the trigger it collects a fixed number of post-trigger samples and stops, so the trigger sample sits at a known distance from the oldest retained sample.

Three acquisition modes are provided. Circular mode uses the whole memory as one region. Segmented mode splits the memory into 1, 2, 4, ... equal segments, captures one trigger event per segment and moves on until the last segment is full. Continuous mode writes forever and never stops. For every segment the memory address of the trigger sample is latched so that readout can rotate each segment back into time order. The memory is a plain inferred array with an asynchronous read port for readout. Deciding when to trigger and moving data to the host are handled elsewhere.

Top module: `capture_ctrl`

## Requirements
- R1: After reset `wr_en_o`, `done_o` and `captured_o` are 0 and no sample is written until `arm_i` is pulsed.
- R2: While running, exactly one sample of `probe_i` is written per clock cycle. Within a segment of length L the write address advances by one each cycle and wraps modulo L. The value written can be read back at that address through `rd_addr_i`/`rd_data_o`.
- R3: The trigger position code `pos_i` sets the number of samples P kept before the trigger. Code 0 keeps P = L/8, code 2 keeps P = L - L/8, and codes 1 and 3 keep P = L/2. After capture, the P samples immediately before the trigger are stored just below the trigger address, modulo L within its segment.
- R4: A trigger is accepted only if at least P samples have been written in the current segment since it started. An earlier trigger pulse is ignored. Only one trigger is accepted per segment.
- R5: After an accepted trigger, exactly L-P-1 further samples are written in that segment. When the last segment completes, `wr_en_o` stays 0 until the next arm.
- R6: The write address of each accepted trigger sample is latched into slot k of `trig_addr_o`, at bits [k*AW +: AW], where k is the segment index.
- R7: `mode_i` code 1 (segmented) uses 2**`seg_log_i` segments (clamped to the maximum). Segment k covers addresses k*L to k*L+L-1, with L = DEPTH >> `seg_log_i`. Segments fill in increasing order. Code 0 (and code 3) is circular mode with one segment of length DEPTH.
- R8: `done_o` is high for exactly the one cycle after the last segment's final write. `captured_o` rises in that same cycle and stays high until the next `arm_i`.
- R9: `mode_i` code 2 (continuous) writes every cycle at address (n mod DEPTH) for the n-th sample after arming. It ignores triggers and never raises `done_o`.
- R10: `arm_i` restarts acquisition at address 0 from any state, including mid-run. A trigger in the arm cycle is ignored. Mode, position and segment count are sampled only in the arm cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Start or restart acquisition; samples the configuration |
| mode_i | input | 2 | 0 circular, 1 segmented, 2 continuous, 3 circular |
| pos_i | input | 2 | Trigger position: 0 early, 1/3 centre, 2 late |
| seg_log_i | input | LW | log2 of the segment count in segmented mode |
| trig_i | input | 1 | Trigger request |
| probe_i | input | DATA_W | Probe bus being recorded |
| wr_en_o | output | 1 | A sample is written this cycle |
| wr_addr_o | output | AW | Memory address of this cycle's sample |
| seg_idx_o | output | SIW | Segment currently being filled |
| done_o | output | 1 | One-cycle pulse when the final segment completes |
| captured_o | output | 1 | Capture complete, held until re-arm |
| trig_addr_o | output | NSEG*AW | Latched trigger-sample address per segment |
| rd_addr_i | input | AW | Readout address |
| rd_data_o | output | DATA_W | Sample stored at `rd_addr_i` |

## Verification
Trigger qualification and segment advance can fall in the same cycle as the pre-trigger count reaching P, and a re-arm can coincide with a trigger request. The bench pulses the trigger one sample before the count is met and again exactly on the boundary. It also re-arms a running continuous capture with the trigger held high in the arm cycle. Each outcome is judged by the latched trigger address, the full memory image and the number of samples written, against an independent model of where every probe value must land.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    M_CIRC = 2'd0,
    M_SEG  = 2'd1,
    M_CONT = 2'd2,
    M_RSV  = 2'd3
  } cap_mode_e;

  typedef enum logic [1:0] {
    P_EARLY = 2'd0,
    P_MID   = 2'd1,
    P_LATE  = 2'd2,
    P_RSV   = 2'd3
  } trig_pos_e;

  // samples retained ahead of the trigger for a region of len entries
  function automatic int unsigned pre_len(input trig_pos_e pos, input int unsigned len);
    case (pos)
      P_EARLY: return len >> 3;
      P_LATE:  return len - (len >> 3);
      default: return len >> 1;
    endcase
  endfunction

endpackage

// File: rtl/cap_ram.sv
module cap_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/cap_seq.sv
module cap_seq
  import cap_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int MAX_SEG_LOG = 2,
  localparam int AW  = $clog2(DEPTH),
  localparam int LW  = $clog2(MAX_SEG_LOG + 2),
  localparam int SIW = (MAX_SEG_LOG > 0) ? MAX_SEG_LOG : 1,
  localparam int CW  = AW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           arm_i,
  input  logic [1:0]     mode_i,
  input  logic [1:0]     pos_i,
  input  logic [LW-1:0]  seg_log_i,
  input  logic           trig_i,
  output logic           wr_en_o,
  output logic [AW-1:0]  wr_addr_o,
  output logic [SIW-1:0] seg_idx_o,
  output logic           hit_o,
  output logic           done_o,
  output logic           captured_o
);

  cap_mode_e      mode_q, mode_d;
  trig_pos_e      pos_q;
  logic [LW-1:0]  slog_q, slog_d;
  logic           run_q, trig_q;
  logic [AW-1:0]  off_q;
  logic [SIW-1:0] seg_q;
  logic [CW-1:0]  fill_q, post_q;

  logic [CW-1:0]  seg_len, pre_cnt, post_len;
  logic [AW-1:0]  off_mask, seg_base;
  logic           seg_last, accept, last_wr, stoppable;

  // configuration decode at arm time
  always_comb begin
    mode_d = cap_mode_e'(mode_i);
    if (mode_d == M_RSV) mode_d = M_CIRC;
    slog_d = '0;
    if (mode_d == M_SEG)
      slog_d = (seg_log_i > LW'(MAX_SEG_LOG)) ? LW'(MAX_SEG_LOG) : seg_log_i;
  end

  assign seg_len   = CW'(DEPTH) >> slog_q;
  assign pre_cnt   = CW'(pre_len(pos_q, 32'(seg_len)));
  assign post_len  = seg_len - pre_cnt - CW'(1);
  assign off_mask  = AW'(seg_len - CW'(1));
  assign seg_base  = AW'(seg_q) << (32'(AW) - 32'(slog_q));
  assign seg_last  = (seg_q == SIW'((32'd1 << slog_q) - 32'd1));
  assign stoppable = run_q && !arm_i && (mode_q != M_CONT);

  assign accept  = stoppable && !trig_q && trig_i && (fill_q >= pre_cnt);
  assign last_wr = stoppable &&
                   ((accept && post_len == '0) || (trig_q && post_q == CW'(1)));

  assign wr_en_o   = run_q && !arm_i;
  assign wr_addr_o = seg_base | off_q;
  assign seg_idx_o = seg_q;
  assign hit_o     = accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= M_CIRC;
      pos_q      <= P_MID;
      slog_q     <= '0;
      run_q      <= 1'b0;
      trig_q     <= 1'b0;
      off_q      <= '0;
      seg_q      <= '0;
      fill_q     <= '0;
      post_q     <= '0;
      done_o     <= 1'b0;
      captured_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (arm_i) begin
        mode_q     <= mode_d;
        pos_q      <= trig_pos_e'(pos_i);
        slog_q     <= slog_d;
        run_q      <= 1'b1;
        trig_q     <= 1'b0;
        off_q      <= '0;
        seg_q      <= '0;
        fill_q     <= '0;
        post_q     <= '0;
        captured_o <= 1'b0;
      end else if (run_q) begin
        off_q <= (off_q + 1'b1) & off_mask;
        if (!trig_q && fill_q < pre_cnt) fill_q <= fill_q + 1'b1;
        if (accept) begin
          trig_q <= 1'b1;
          post_q <= post_len;
        end else if (trig_q) begin
          post_q <= post_q - 1'b1;
        end
        if (last_wr) begin
          if (seg_last) begin
            run_q      <= 1'b0;
            done_o     <= 1'b1;
            captured_o <= 1'b1;
          end else begin
            seg_q  <= seg_q + 1'b1;
            off_q  <= '0;
            fill_q <= '0;
            trig_q <= 1'b0;
          end
        end
      end
    end
  end

  p_addr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !last_wr) |=> (!wr_en_o || off_q == ((AW'($past(off_q)) + 1'b1) & off_mask)));

  p_single_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !last_wr) |=> !hit_o);

  p_halt_after_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i) |-> !wr_en_o);

  p_seg_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !arm_i) |=> (seg_q == $past(seg_q) || seg_q == $past(seg_q) + 1'b1));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_captured_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (captured_o && !arm_i) |=> captured_o);

  p_cont_runs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && mode_q == M_CONT && !arm_i) |=> (run_q && !done_o));

  p_arm_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (run_q && wr_addr_o == '0 && !captured_o && !trig_q));

endmodule

// File: rtl/cap_trig_bank.sv
module cap_trig_bank #(
  parameter int NSEG = 4,
  parameter int AW   = 6,
  localparam int SIW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic [SIW-1:0]   slot_i,
  input  logic [AW-1:0]    addr_i,
  output logic [NSEG*AW-1:0] addr_o
);

  for (genvar g = 0; g < NSEG; g++) begin : g_slot
    logic [AW-1:0] slot_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              slot_q <= '0;
      else if (clr_i)                           slot_q <= '0;
      else if (hit_i && slot_i == SIW'(g))      slot_q <= addr_i;
    end

    assign addr_o[g*AW +: AW] = slot_q;

    p_latch_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_i && !clr_i && slot_i == SIW'(g)) |=> (addr_o[g*AW +: AW] == $past(addr_i)));
  end

endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import cap_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DEPTH       = 64,
  parameter int MAX_SEG_LOG = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(MAX_SEG_LOG + 2),
  localparam int NSEG = 1 << MAX_SEG_LOG,
  localparam int SIW  = (MAX_SEG_LOG > 0) ? MAX_SEG_LOG : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 arm_i,
  input  logic [1:0]           mode_i,
  input  logic [1:0]           pos_i,
  input  logic [LW-1:0]        seg_log_i,
  input  logic                 trig_i,
  input  logic [DATA_W-1:0]    probe_i,
  output logic                 wr_en_o,
  output logic [AW-1:0]        wr_addr_o,
  output logic [SIW-1:0]       seg_idx_o,
  output logic                 done_o,
  output logic                 captured_o,
  output logic [NSEG*AW-1:0]   trig_addr_o,
  input  logic [AW-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o
);

  logic hit;

  cap_seq #(
    .DEPTH       (DEPTH),
    .MAX_SEG_LOG (MAX_SEG_LOG)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm_i),
    .mode_i     (mode_i),
    .pos_i      (pos_i),
    .seg_log_i  (seg_log_i),
    .trig_i     (trig_i),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .seg_idx_o  (seg_idx_o),
    .hit_o      (hit),
    .done_o     (done_o),
    .captured_o (captured_o)
  );

  cap_trig_bank #(
    .NSEG (NSEG),
    .AW   (AW)
  ) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (arm_i),
    .hit_i  (hit),
    .slot_i (seg_idx_o),
    .addr_i (wr_addr_o),
    .addr_o (trig_addr_o)
  );

  cap_ram #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) i_ram (
    .clk_i   (clk_i),
    .we_i    (wr_en_o),
    .waddr_i (wr_addr_o),
    .wdata_i (probe_i),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  p_idle_after_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_en_o) && !$past(arm_i) && !wr_en_o) |=> (!wr_en_o || arm_i || $past(arm_i)));

endmodule

// File: tb/test_capture_ctrl.sv
module test_capture_ctrl;

  localparam int DW = 16;
  localparam int DEPTH = 64;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic [1:0] mode = '0;
  logic [1:0] pos = '0;
  logic [1:0] slog = '0;
  logic trig = 1'b0;
  logic [DW-1:0] probe = '0;
  logic wr_en;
  logic [AW-1:0] wr_addr;
  logic [1:0] seg_idx;
  logic done, captured;
  logic [4*AW-1:0] taddr;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int fails = 0;
  int k = 0;
  int exp_mem [DEPTH];
  bit exp_val [DEPTH];
  int exp_trig [4];
  int trig_val [4];

  always #4 clk = ~clk;

  capture_ctrl #(.DATA_W(DW), .DEPTH(DEPTH), .MAX_SEG_LOG(2)) i_capture_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .mode_i(mode), .pos_i(pos),
    .seg_log_i(slog), .trig_i(trig), .probe_i(probe), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .seg_idx_o(seg_idx), .done_o(done), .captured_o(captured),
    .trig_addr_o(taddr), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1;
    chk(wr_en == 1'b0, "R1", "wr_en after reset", int'(wr_en), 0);
    chk(done == 1'b0 && captured == 1'b0, "R1", "done/captured after reset", int'({done, captured}), 0);
    repeat (3) @(negedge clk);
    #1;
    chk(wr_en == 1'b0, "R1", "wr_en idle without arm", int'(wr_en), 0);
    @(negedge clk);
  endtask

  // continuous mode: never stops, trigger ignored (R9)
  task automatic t_continuous(input int ncyc);
    int bad = 0;
    int first_bad = 0;
    arm = 1'b1; mode = 2'd2; pos = 2'd0; slog = 2'd0; trig = 1'b0;
    @(posedge clk);
    @(negedge clk);
    arm = 1'b0; mode = 2'd0;
    for (int i = 0; i < ncyc; i++) begin
      probe = DW'(k);
      trig = (i % 10 == 3);
      #1;
      if (!(wr_en && wr_addr == AW'(i % DEPTH) && !done)) begin
        if (bad == 0) first_bad = i;
        bad++;
      end
      @(posedge clk);
      exp_mem[i % DEPTH] = k; exp_val[i % DEPTH] = 1'b1; k++;
      @(negedge clk);
    end
    trig = 1'b0;
    chk(bad == 0, "R9", "continuous write/address mismatches", bad, 0);
    if (bad != 0) $display("  first mismatch at sample %0d", first_bad);
    #1;
    chk(wr_en == 1'b1 && captured == 1'b0, "R9", "still running, no capture", int'({wr_en, captured}), 2);
  endtask

  // one triggered acquisition; model fixes every address and value
  task automatic t_capture(input int md, input int ps, input int sl, input int early_j,
                           input int trig_j, input bit arm_trig, input string tag);
    int sl_e, L, nseg, P, s, j, rem, a, addr_bad, done_bad, writes, obs, bad_img, expw;
    bit trg, endseg;
    sl_e = (md == 1) ? ((sl > 2) ? 2 : sl) : 0;
    L = DEPTH >> sl_e;
    nseg = 1 << sl_e;
    P = (ps == 0) ? L / 8 : (ps == 2) ? L - L / 8 : L / 2;
    expw = nseg * (trig_j + L - P);
    arm = 1'b1; mode = 2'(md); pos = 2'(ps); slog = 2'(sl); trig = arm_trig;
    @(posedge clk);
    @(negedge clk);
    arm = 1'b0; mode = 2'd2; pos = 2'd3; slog = 2'd0;   // R10: later config must not matter
    s = 0; j = 0; trg = 0; rem = 0; addr_bad = 0; done_bad = 0; writes = 0; obs = 0;
    while (s < nseg) begin
      probe = DW'(k);
      trig = (j == early_j) || (j == trig_j);
      #1;
      a = s * L + (j % L);
      if (wr_en) obs++;
      if (!(wr_en && wr_addr == AW'(a))) addr_bad++;
      if (done || captured) done_bad++;
      @(posedge clk);
      exp_mem[a] = k; exp_val[a] = 1'b1; writes++;
      endseg = 0;
      if (!trg && j == trig_j) begin
        trg = 1; exp_trig[s] = a; trig_val[s] = k; rem = L - P - 1; endseg = (rem == 0);
      end else if (trg) begin
        endseg = (rem == 1); rem--;
      end
      k++; j++;
      if (endseg) begin s++; j = 0; trg = 0; end
      @(negedge clk);
    end
    trig = 1'b0;
    #1;
    chk(addr_bad == 0, "R2", {tag, " write address sequence"}, addr_bad, 0);
    chk(obs == expw, "R5", {tag, " samples written"}, obs, expw);
    chk(done == 1'b1, "R8", {tag, " done after last write"}, int'(done), 1);
    chk(captured == 1'b1, "R8", {tag, " captured set"}, int'(captured), 1);
    chk(wr_en == 1'b0, "R5", {tag, " writes stop"}, int'(wr_en), 0);
    chk(done_bad == 0, "R8", {tag, " done/captured early"}, done_bad, 0);
    @(negedge clk);
    #1;
    chk(done == 1'b0 && captured == 1'b1 && wr_en == 1'b0, "R8", {tag, " done one cycle, status held"},
        int'({done, captured, wr_en}), 2);
    for (int g = 0; g < nseg; g++)
      chk(int'(taddr[g*AW +: AW]) == exp_trig[g], (nseg > 1) ? "R7" : "R6",
          {tag, " trigger address slot"}, int'(taddr[g*AW +: AW]), exp_trig[g]);
    bad_img = 0;
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr = AW'(i);
      #1;
      if (exp_val[i] && int'(rd_data) != (exp_mem[i] & 16'hFFFF)) bad_img++;
    end
    chk(bad_img == 0, "R2", {tag, " memory image"}, bad_img, 0);
    for (int g = 0; g < nseg; g++) begin
      a = g * L + ((exp_trig[g] - g * L - P + L) % L);
      rd_addr = AW'(a);
      #1;
      chk(int'(rd_data) == ((trig_val[g] - P) & 16'hFFFF), "R3", {tag, " oldest pre-trigger sample"},
          int'(rd_data), (trig_val[g] - P) & 16'hFFFF);
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin exp_mem[i] = 0; exp_val[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_continuous(150);
    // R10: re-arm mid continuous run with trigger held in the arm cycle; R4 early pulse at 5 (<8)
    t_capture(0, 0, 3, 5, 69, 1'b1, "circ_early_wrap");
    // R3/R4: centre, trigger one before and exactly at the qualification boundary
    t_capture(0, 1, 0, 31, 32, 1'b0, "circ_mid_boundary");
    t_capture(3, 2, 0, 50, 60, 1'b0, "circ_late");
    // R7: four and two segments
    t_capture(1, 1, 2, 7, 8, 1'b0, "seg4_mid");
    t_capture(1, 0, 1, 3, 10, 1'b0, "seg2_early");
    t_capture(1, 2, 2, 13, 20, 1'b0, "seg4_late_wrap");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule